// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block is the trap control slice of a small in-order core. On the entry side it turns a software trap request into a vector number. It adds a base and an offset and folds the sum into the upper half of the vector space. On the return side it takes a return-from-trap request and judges it against the current status bits: supervisor, trap-enable and previous-supervisor. It also looks at the debug-mode flag and the debug-select bit carried by the instruction.

For each return request the block gives the next fetch address in the same cycle. On the next clock edge it gives either a status update, a halt request or an illegal-instruction request. A debug-exit strobe goes with a return from debug mode. The register file that holds the status bits, the exception queue and the fetch unit sit outside the block. They consume the registered update and request pulses.

The legality check runs in a fixed order. A user-mode return with traps disabled halts. A user-mode return with traps enabled only steps on, because the privilege fault is raised elsewhere. A supervisor return with traps already enabled is illegal. Only a supervisor return with traps disabled may restore state: from the normal saved PC when not in debug mode with the select bit at 0, or from the debug saved PC when in debug mode with the select bit at 1.

Top module: `trap_return_ctrl`

## Requirements
- R1: One clock edge after `trap_req` is high, `trap_vec_vld` is high for one cycle. `trap_vec` then equals ((`trap_base` + `trap_ofs`) mod 128) + 128.
- R2: When `trap_vec_vld` is high, `trap_vec` always lies in 0x80..0xFF: bit 7 is set whatever the base and offset, including sums that wrap.
- R3: A return with supervisor=0 and trap-enable=0 gives `next_pc` = `cur_pc`+4 in the same cycle. On the next edge it gives a one-cycle `halt_req` and no status update.
- R4: A return with supervisor=0 and trap-enable=1 gives `next_pc` = `cur_pc`+4, and no halt, illegal, update or debug-exit pulse on the next edge.
- R5: A return with supervisor=1 and trap-enable=1 gives `next_pc` = `cur_pc`+4 and, on the next edge, a one-cycle `illegal_req` and no status update.
- R6: A return with supervisor=1, trap-enable=0, `in_debug`=0 and `ret_dbg_sel`=0 gives `next_pc` = `saved_pc`. On the next edge it gives `upd_vld`=1 with `upd_trap_en`=1 and `upd_sup` equal to the previous-supervisor bit.
- R7: A return with supervisor=1, trap-enable=0, `in_debug`=1 and `ret_dbg_sel`=1 gives `next_pc` = `dbg_saved_pc`. On the next edge it gives `upd_vld`=1 with `upd_trap_en`=`dbg_saved_en`, `upd_sup`=`dbg_saved_sup`, and a one-cycle `dbg_exit`.
- R8: A return with supervisor=1 and trap-enable=0 whose `in_debug` and `ret_dbg_sel` differ gives `next_pc` = `cur_pc`+4, and no update or pulse on the next edge.
- R9: `next_pc_vld` equals `ret_req`. Every registered pulse lasts exactly one cycle per request, and at most one of `halt_req` and `illegal_req` is high in any cycle.
- R10: After reset, all registered outputs (`trap_vec_vld`, `upd_vld`, `dbg_exit`, `halt_req`, `illegal_req`) are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Software trap request |
| trap_base | input | 32 | Trap number base operand |
| trap_ofs | input | 32 | Trap number offset operand |
| trap_vec_vld | output | 1 | Trap vector valid pulse |
| trap_vec | output | 8 | Computed trap vector number |
| ret_req | input | 1 | Return-from-trap request |
| ret_dbg_sel | input | 1 | Debug-select bit of the return instruction |
| st_sup | input | 1 | Current supervisor bit |
| st_trap_en | input | 1 | Current trap-enable bit |
| st_prev_sup | input | 1 | Previous-supervisor bit |
| in_debug | input | 1 | Core is in debug mode |
| cur_pc | input | 32 | Address of the return instruction |
| saved_pc | input | 32 | Normal saved return address |
| dbg_saved_pc | input | 32 | Debug saved return address |
| dbg_saved_en | input | 1 | Saved debug trap-enable bit |
| dbg_saved_sup | input | 1 | Saved debug supervisor bit |
| next_pc_vld | output | 1 | Next PC valid (same cycle as request) |
| next_pc | output | 32 | Next fetch address |
| upd_vld | output | 1 | Status update strobe |
| upd_sup | output | 1 | New supervisor bit |
| upd_trap_en | output | 1 | New trap-enable bit |
| dbg_exit | output | 1 | Leave-debug-mode strobe |
| halt_req | output | 1 | Halt request pulse |
| illegal_req | output | 1 | Illegal-instruction request pulse |

## Verification
`next_pc` and `next_pc_vld` are combinational. The bench checks them shortly after it drives the request at a falling edge, in the same cycle. The trap vector, status update, debug exit and both request pulses pass through one register. The bench samples them at the falling edge after the rising edge that captures the request. It then drops the request and samples once more a cycle later to confirm that each pulse has ended. Each return scenario also checks that every output it must not touch stays low in that same registered cycle.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;

  typedef enum logic [2:0] {
    RK_NONE    = 3'd0,
    RK_HALT    = 3'd1,
    RK_USER    = 3'd2,
    RK_ILLEGAL = 3'd3,
    RK_NORMAL  = 3'd4,
    RK_DEBUG   = 3'd5,
    RK_SKIP    = 3'd6
  } ret_kind_e;

  typedef struct packed {
    logic sup;
    logic trap_en;
  } stat_t;

endpackage

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
  parameter int XLEN     = 32,
  parameter int VEC_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trap_req,
  input  logic [XLEN-1:0]     trap_base,
  input  logic [XLEN-1:0]     trap_ofs,
  output logic                trap_vec_vld,
  output logic [VEC_BITS-1:0] trap_vec
);
  localparam int LOW_BITS = VEC_BITS - 1;

  logic [XLEN-1:0] sum;
  assign sum = trap_base + trap_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_vec_vld <= 1'b0;
      trap_vec     <= '0;
    end else begin
      trap_vec_vld <= trap_req;
      if (trap_req) trap_vec <= {1'b1, sum[LOW_BITS-1:0]};
    end
  end

  // R1: the pulse follows a request by one edge and lasts one cycle
  a_r1_vec_pulse: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> trap_vec_vld);
  a_r1_vec_idle: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> !trap_vec_vld);
  // R2: the vector stays in the upper half
  a_r2_vec_range: assert property (@(posedge clk) disable iff (rst)
    trap_vec_vld |-> trap_vec[VEC_BITS-1]);

endmodule

// File: rtl/ret_classifier.sv
module ret_classifier
  import trap_ctrl_pkg::*;
(
  input  logic      ret_req,
  input  logic      ret_dbg_sel,
  input  logic      st_sup,
  input  logic      st_trap_en,
  input  logic      in_debug,
  output ret_kind_e kind
);
  // Ordered legality check: user mode first, then enabled supervisor,
  // then the two permitted restore sources.
  always_comb begin
    kind = RK_NONE;
    if (ret_req) begin
      if (!st_sup) begin
        kind = st_trap_en ? RK_USER : RK_HALT;
      end else if (st_trap_en) begin
        kind = RK_ILLEGAL;
      end else if (!in_debug && !ret_dbg_sel) begin
        kind = RK_NORMAL;
      end else if (in_debug && ret_dbg_sel) begin
        kind = RK_DEBUG;
      end else begin
        kind = RK_SKIP;
      end
    end
  end

endmodule

// File: rtl/ret_outcome_reg.sv
module ret_outcome_reg
  import trap_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ret_kind_e kind,
  input  logic      st_prev_sup,
  input  logic      dbg_saved_en,
  input  logic      dbg_saved_sup,
  output logic      upd_vld,
  output stat_t     upd_stat,
  output logic      dbg_exit,
  output logic      halt_req,
  output logic      illegal_req
);
  stat_t nxt_stat;

  always_comb begin
    nxt_stat = '0;
    if (kind == RK_NORMAL) begin
      nxt_stat.sup     = st_prev_sup;
      nxt_stat.trap_en = 1'b1;
    end else if (kind == RK_DEBUG) begin
      nxt_stat.sup     = dbg_saved_sup;
      nxt_stat.trap_en = dbg_saved_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_vld     <= 1'b0;
      upd_stat    <= '0;
      dbg_exit    <= 1'b0;
      halt_req    <= 1'b0;
      illegal_req <= 1'b0;
    end else begin
      upd_vld     <= (kind == RK_NORMAL) || (kind == RK_DEBUG);
      dbg_exit    <= (kind == RK_DEBUG);
      halt_req    <= (kind == RK_HALT);
      illegal_req <= (kind == RK_ILLEGAL);
      if ((kind == RK_NORMAL) || (kind == RK_DEBUG)) upd_stat <= nxt_stat;
    end
  end

  // R9: the two requests never coincide
  a_r9_one_exc: assert property (@(posedge clk) disable iff (rst)
    $countones({halt_req, illegal_req, upd_vld}) <= 1);
  // R7: a debug exit always carries a status update
  a_r7_exit_upd: assert property (@(posedge clk) disable iff (rst)
    dbg_exit |-> upd_vld);

endmodule

// File: rtl/trap_return_ctrl.sv
module trap_return_ctrl
  import trap_ctrl_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int VEC_BITS = 8,
  parameter int PC_STEP  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trap_req,
  input  logic [XLEN-1:0]     trap_base,
  input  logic [XLEN-1:0]     trap_ofs,
  output logic                trap_vec_vld,
  output logic [VEC_BITS-1:0] trap_vec,
  input  logic                ret_req,
  input  logic                ret_dbg_sel,
  input  logic                st_sup,
  input  logic                st_trap_en,
  input  logic                st_prev_sup,
  input  logic                in_debug,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [XLEN-1:0]     saved_pc,
  input  logic [XLEN-1:0]     dbg_saved_pc,
  input  logic                dbg_saved_en,
  input  logic                dbg_saved_sup,
  output logic                next_pc_vld,
  output logic [XLEN-1:0]     next_pc,
  output logic                upd_vld,
  output logic                upd_sup,
  output logic                upd_trap_en,
  output logic                dbg_exit,
  output logic                halt_req,
  output logic                illegal_req
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  ret_kind_e kind;
  stat_t     upd_stat;

  trap_vector_gen #(.XLEN(XLEN), .VEC_BITS(VEC_BITS)) u_vec (
    .clk(clk), .rst(rst), .trap_req(trap_req),
    .trap_base(trap_base), .trap_ofs(trap_ofs),
    .trap_vec_vld(trap_vec_vld), .trap_vec(trap_vec)
  );

  ret_classifier u_cls (
    .ret_req(ret_req), .ret_dbg_sel(ret_dbg_sel), .st_sup(st_sup),
    .st_trap_en(st_trap_en), .in_debug(in_debug), .kind(kind)
  );

  ret_outcome_reg u_out (
    .clk(clk), .rst(rst), .kind(kind), .st_prev_sup(st_prev_sup),
    .dbg_saved_en(dbg_saved_en), .dbg_saved_sup(dbg_saved_sup),
    .upd_vld(upd_vld), .upd_stat(upd_stat), .dbg_exit(dbg_exit),
    .halt_req(halt_req), .illegal_req(illegal_req)
  );

  assign upd_sup     = upd_stat.sup;
  assign upd_trap_en = upd_stat.trap_en;
  assign next_pc_vld = ret_req;

  always_comb begin
    case (kind)
      RK_NORMAL: next_pc = saved_pc;
      RK_DEBUG:  next_pc = dbg_saved_pc;
      default:   next_pc = cur_pc + STEP;
    endcase
  end

  // R3: user return with traps off halts and updates nothing
  a_r3_halt: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !st_sup && !st_trap_en) |=> (halt_req && !upd_vld));
  // R5: supervisor return with traps on is illegal
  a_r5_illegal: assert property (@(posedge clk) disable iff (rst)
    (ret_req && st_sup && st_trap_en) |=> (illegal_req && !upd_vld));
  // R6: normal restore re-enables traps
  a_r6_normal: assert property (@(posedge clk) disable iff (rst)
    (ret_req && st_sup && !st_trap_en && !in_debug && !ret_dbg_sel)
      |=> (upd_vld && upd_trap_en && !dbg_exit));
  // R8: mismatched mode and select changes nothing
  a_r8_skip: assert property (@(posedge clk) disable iff (rst)
    (ret_req && st_sup && !st_trap_en && (in_debug != ret_dbg_sel))
      |=> !(upd_vld || halt_req || illegal_req || dbg_exit));
  // R10: no registered output without a request the cycle before
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !ret_req |=> !(upd_vld || halt_req || illegal_req || dbg_exit));

endmodule

// File: tb/tb_trap_return_ctrl.sv
module tb_trap_return_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        trap_req;
  logic [31:0] trap_base, trap_ofs;
  logic        trap_vec_vld;
  logic [7:0]  trap_vec;
  logic        ret_req, ret_dbg_sel, st_sup, st_trap_en, st_prev_sup, in_debug;
  logic [31:0] cur_pc, saved_pc, dbg_saved_pc;
  logic        dbg_saved_en, dbg_saved_sup;
  logic        next_pc_vld;
  logic [31:0] next_pc;
  logic        upd_vld, upd_sup, upd_trap_en, dbg_exit, halt_req, illegal_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  trap_return_ctrl dut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_base(trap_base),
    .trap_ofs(trap_ofs), .trap_vec_vld(trap_vec_vld), .trap_vec(trap_vec),
    .ret_req(ret_req), .ret_dbg_sel(ret_dbg_sel), .st_sup(st_sup),
    .st_trap_en(st_trap_en), .st_prev_sup(st_prev_sup), .in_debug(in_debug),
    .cur_pc(cur_pc), .saved_pc(saved_pc), .dbg_saved_pc(dbg_saved_pc),
    .dbg_saved_en(dbg_saved_en), .dbg_saved_sup(dbg_saved_sup),
    .next_pc_vld(next_pc_vld), .next_pc(next_pc), .upd_vld(upd_vld),
    .upd_sup(upd_sup), .upd_trap_en(upd_trap_en), .dbg_exit(dbg_exit),
    .halt_req(halt_req), .illegal_req(illegal_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // flags packed as {upd_vld, upd_sup, upd_trap_en, dbg_exit, halt_req, illegal_req}
  function automatic logic [5:0] regs_now();
    return {upd_vld, upd_sup, upd_trap_en, dbg_exit, halt_req, illegal_req};
  endfunction

  task automatic run_trap(input logic [31:0] b, input logic [31:0] o, input string req);
    logic [31:0] s;
    logic [7:0]  exp;
    s   = b + o;
    exp = {1'b0, s[6:0]} + 8'h80;
    @(negedge clk);
    trap_base = b; trap_ofs = o; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    chk({req, " vec_vld"}, {31'd0, trap_vec_vld}, 32'd1);
    chk({req, " vec"}, {24'd0, trap_vec}, {24'd0, exp});
    chk("R2 vec range", {31'd0, trap_vec[7]}, 32'd1);
    @(negedge clk);
    chk({req, " vec pulse ends"}, {31'd0, trap_vec_vld}, 32'd0);
  endtask

  // Exp flags use the packing of regs_now; upd_sup/upd_trap_en only compared when updating
  task automatic run_ret(input string req, input logic s, input logic e, input logic ps,
                         input logic dbg, input logic sel, input logic [31:0] exp_pc,
                         input logic [5:0] exp_flags);
    logic [5:0] got;
    @(negedge clk);
    st_sup = s; st_trap_en = e; st_prev_sup = ps; in_debug = dbg; ret_dbg_sel = sel;
    ret_req = 1'b1;
    #1;
    chk({req, " next_pc_vld R9"}, {31'd0, next_pc_vld}, 32'd1);
    chk({req, " next_pc"}, next_pc, exp_pc);
    @(negedge clk);
    got = regs_now();
    if (!exp_flags[5]) got[4:3] = 2'b00;
    chk({req, " registered flags"}, {26'd0, got}, {26'd0, exp_flags});
    ret_req = 1'b0;
    #1;
    chk({req, " next_pc_vld drop R9"}, {31'd0, next_pc_vld}, 32'd0);
    @(negedge clk);
    chk({req, " pulses end R9"}, {26'd0, regs_now() & 6'b100111}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    trap_req = 0; trap_base = 0; trap_ofs = 0;
    ret_req = 0; ret_dbg_sel = 0; st_sup = 0; st_trap_en = 0; st_prev_sup = 0;
    in_debug = 0; cur_pc = 32'h0000_1000; saved_pc = 32'h0000_4440;
    dbg_saved_pc = 32'h0000_8880; dbg_saved_en = 0; dbg_saved_sup = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset vec_vld", {31'd0, trap_vec_vld}, 32'd0);
    chk("R10 reset flags", {26'd0, regs_now() & 6'b100111}, 32'd0);
  endtask

  initial begin
    t_reset();
    run_trap(32'h0, 32'h0, "R1 zero");
    run_trap(32'h12, 32'h34, "R1 mid");
    run_trap(32'h7F, 32'h1, "R2 wrap to 0x80");
    run_trap(32'h100, 32'hFFFF_FFFF, "R2 negative offset");
    run_trap(32'hFFFF_FFF0, 32'h2F, "R1 carry out");

    cur_pc = 32'h0000_2000;
    run_ret("R3 halt", 0, 0, 1, 0, 0, 32'h0000_2004, 6'b000010);
    run_ret("R4 user", 0, 1, 1, 1, 1, 32'h0000_2004, 6'b000000);
    run_ret("R5 illegal", 1, 1, 0, 0, 0, 32'h0000_2004, 6'b000001);
    run_ret("R6 normal ps=1", 1, 0, 1, 0, 0, 32'h0000_4440, 6'b111000);
    run_ret("R6 normal ps=0", 1, 0, 0, 0, 0, 32'h0000_4440, 6'b101000);
    dbg_saved_en = 1'b0; dbg_saved_sup = 1'b1;
    run_ret("R7 debug en0 sup1", 1, 0, 0, 1, 1, 32'h0000_8880, 6'b110100);
    dbg_saved_en = 1'b1; dbg_saved_sup = 1'b0;
    run_ret("R7 debug en1 sup0", 1, 0, 1, 1, 1, 32'h0000_8880, 6'b101100);
    run_ret("R8 normal mode sel1", 1, 0, 1, 0, 1, 32'h0000_2004, 6'b000000);
    run_ret("R8 debug mode sel0", 1, 0, 1, 1, 0, 32'h0000_2004, 6'b000000);
    cur_pc = 32'hFFFF_FFFC;
    run_ret("R3 halt pc wrap", 0, 0, 0, 1, 0, 32'h0000_0000, 6'b000010);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule